// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, numbered 0 to 7, and turns them into one global interrupt plus the index of the most urgent pending request. Line 7 has the highest priority and line 0 the lowest. Each line can be set to edge or level sensing and can be masked on its own. A masked line never becomes pending.

A processor sets the block up and services it through a small register bus. It can write the mask and mode registers, read the pending word, and read a clear port. Reading the clear port returns the pending word and drops every pending edge-sensed request. A level-sensed request stays pending for as long as its line stays high. The global output and the encoded index follow the pending word. Software normally takes the highest-priority request, services it, and reads the clear port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 8'hFF (all lines masked), the mode register reads 8'h00, the pending word reads 8'h00, and `irqOut` and `irqValid` are 0.
- R2: A mask bit of 1 keeps its line from becoming pending. Writing a mask bit to 1 clears that line's pending bit on the clock edge of the write.
- R3: A line whose mode bit is 0 is level-sensed. Its pending bit equals the line value ANDed with the inverse of its mask, registered once, with no hold.
- R4: A line whose mode bit is 1 is edge-sensed. A 0-to-1 change between two consecutive clock samples sets its pending bit. The bit stays set after the line falls.
- R5: A read at bus address 3 returns the pending word and clears every pending edge-sensed bit. Level-sensed bits are unaffected and stay set while their lines are high.
- R6: A rising edge on an unmasked edge-sensed line in the same cycle as a read at address 3 leaves that line pending.
- R7: `irqIdx` gives the index of the highest set pending bit (bit 7 highest), and `irqValid` is 1 exactly when some bit is pending. This way an empty word can be told apart from a word with only line 0 pending.
- R8: `irqOut` is 1 exactly when at least one pending bit is set.
- R9: Bus map: address 0 is the mask (read/write), address 1 is the mode (read/write), address 2 is the pending word (read-only, and reading it clears nothing), and address 3 is the clear port. Writes to addresses 2 and 3 have no effect. `busRdata` shows the addressed register in the same cycle as the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 8 | Interrupt request lines |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| irqOut | output | 1 | Global interrupt |
| irqIdx | output | 3 | Index of the highest-priority pending line |
| irqValid | output | 1 | `irqIdx` is meaningful |

## Verification
The bench targets the race between a new rising edge and a clear read. A design that lets the clear win would lose that interrupt. It also checks that a level line survives a clear read, because a design that clears every bit would drop it. It confirms that a pending edge request is removed at once when the line is masked, since a design that only gates new edges would keep it. Reads at address 2 are checked for leaving the pending word intact, and random traffic against a reference model exercises the priority encoder, where a wrong scan direction would report the lowest line instead of the highest.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_CLR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    maskWr;
    logic    modeWr;
    logic    clrRd;
    regSel_e rdSel;
  } ctrlStb_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStb_t          stb
);
  always_comb begin
    stb.rdSel  = regSel_e'(busAddr);
    stb.maskWr = busSel && busWr && (regSel_e'(busAddr) == REG_MASK);
    stb.modeWr = busSel && busWr && (regSel_e'(busAddr) == REG_MODE);
    stb.clrRd  = busSel && !busWr && (regSel_e'(busAddr) == REG_CLR);
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskWr, stb.modeWr, stb.clrRd}));
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = $clog2(NUM_IRQ)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  ctrlStb_t           stb,
  input  logic [NUM_IRQ-1:0] busWdata,
  output logic [NUM_IRQ-1:0] busRdata,
  output logic [NUM_IRQ-1:0] pendOut,
  output logic [IDX_W-1:0]   irqIdx,
  output logic               irqValid
);
  logic [NUM_IRQ-1:0] maskQ, modeQ, prevQ, pendQ;
  logic [NUM_IRQ-1:0] maskNext, modeNext, riseVec, pendNext;

  assign maskNext = stb.maskWr ? busWdata : maskQ;
  assign modeNext = stb.modeWr ? busWdata : modeQ;
  assign riseVec  = irqIn & ~prevQ;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_comb begin
      if (modeQ[g])
        pendNext[g] = ((pendQ[g] && !stb.clrRd) || riseVec[g]) && !maskNext[g];
      else
        pendNext[g] = irqIn[g] && !maskNext[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      modeQ <= '0;
      prevQ <= '0;
      pendQ <= '0;
    end else begin
      maskQ <= maskNext;
      modeQ <= modeNext;
      prevQ <= irqIn;
      pendQ <= pendNext;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      REG_MASK: busRdata = maskQ;
      REG_MODE: busRdata = modeQ;
      default:  busRdata = pendQ;
    endcase
  end

  always_comb begin
    irqIdx   = '0;
    irqValid = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pendQ[i]) begin
        irqIdx   = IDX_W'(i);
        irqValid = 1'b1;
      end
    end
  end

  assign pendOut = pendQ;

  // R2
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ & maskQ) == '0);
  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(modeQ)) == ($past(irqIn) & ~$past(maskNext) & ~$past(modeQ))));
  // R5
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrRd |=> ((pendQ & $past(modeQ) & ~$past(riseVec)) == '0));
  // R7
  top_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (pendQ[irqIdx] && ((pendQ >> irqIdx) == 1)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_IRQ-1:0] busWdata,
  output logic [NUM_IRQ-1:0] busRdata,
  output logic               irqOut,
  output logic [IDX_W-1:0]   irqIdx,
  output logic               irqValid
);
  ctrlStb_t           stb;
  logic [NUM_IRQ-1:0] pend;

  pic_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  pic_datapath #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pendOut  (pend),
    .irqIdx   (irqIdx),
    .irqValid (irqValid)
  );

  assign irqOut = |pend;

  // R8
  global_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == irqValid);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] irqIn, busWdata, busRdata;
  logic       busSel, busWr, irqOut, irqValid;
  logic [1:0] busAddr;
  logic [2:0] irqIdx;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .irqIdx(irqIdx), .irqValid(irqValid)
  );

  typedef struct {
    logic [2:0] idx;
    logic       vld;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic [7:0] mMask, mMode, mPend, mPrev;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] topIdx(logic [7:0] p);
    logic [2:0] r = '0;
    for (int i = 0; i < 8; i++) if (p[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [7:0] expRd(logic [1:0] a);
    case (a)
      2'd0:    return mMask;
      2'd1:    return mMode;
      default: return mPend;
    endcase
  endfunction

  task automatic step(logic [7:0] irq, logic sel, logic wr, logic [1:0] a,
                      logic [7:0] wd, string tag);
    logic [7:0] mN, dN, pn;
    logic clr;
    exp_t e;
    @(negedge clk);
    irqIn = irq; busSel = sel; busWr = wr; busAddr = a; busWdata = wd;
    #1;
    if (sel && !wr) chk(tag, "rdata", busRdata, expRd(a));
    mN = (sel && wr && a == 2'd0) ? wd : mMask;
    dN = (sel && wr && a == 2'd1) ? wd : mMode;
    clr = sel && !wr && a == 2'd3;
    for (int i = 0; i < 8; i++) begin
      if (mMode[i]) pn[i] = ((mPend[i] && !clr) || (irq[i] && !mPrev[i])) && !mN[i];
      else          pn[i] = irq[i] && !mN[i];
    end
    mPrev = irq; mMask = mN; mMode = dN; mPend = pn;
    e.idx = topIdx(pn); e.vld = |pn; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d, logic [7:0] irq, string tag);
    step(irq, 1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rdReg(logic [1:0] a, logic [7:0] irq, string tag);
    step(irq, 1'b1, 1'b0, a, 8'h00, tag);
  endtask
  task automatic idle(logic [7:0] irq, string tag);
    step(irq, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  // monitor: compare outputs after each clock edge against the scoreboard
  initial forever begin
    @(posedge clk);
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.tag, "irqValid", irqValid, e.vld);
      chk(e.tag, "irqOut R8", irqOut, e.vld);
      if (e.vld) chk(e.tag, "irqIdx", irqIdx, e.idx);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqIn = '0; busSel = 0; busWr = 0; busAddr = '0; busWdata = '0;
    mMask = 8'hFF; mMode = '0; mPend = '0; mPrev = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "irqOut", irqOut, 1'b0);
    chk("R1", "irqValid", irqValid, 1'b0);
    rdReg(2'd0, 8'h00, "R1");
    rdReg(2'd1, 8'h00, "R1");
    rdReg(2'd2, 8'h00, "R1");
    // R2: masked lines stay idle
    idle(8'hFF, "R2");
    rdReg(2'd2, 8'hFF, "R2");
    idle(8'h00, "R2");
    // R3: level mode follows the line
    wrReg(2'd0, 8'h00, 8'h00, "R9");
    rdReg(2'd0, 8'h00, "R9");
    idle(8'h05, "R3");
    rdReg(2'd2, 8'h05, "R3");
    idle(8'h01, "R7");
    rdReg(2'd2, 8'h01, "R3");
    idle(8'h00, "R3");
    rdReg(2'd2, 8'h00, "R3");
    // R4: upper nibble edge-sensed
    wrReg(2'd1, 8'hF0, 8'h00, "R9");
    rdReg(2'd1, 8'h00, "R9");
    idle(8'h10, "R4");
    idle(8'h00, "R4");
    idle(8'h80, "R7");
    idle(8'h02, "R4");
    rdReg(2'd2, 8'h02, "R4");
    rdReg(2'd2, 8'h02, "R9");
    wrReg(2'd2, 8'h00, 8'h02, "R9");
    wrReg(2'd3, 8'h00, 8'h02, "R9");
    rdReg(2'd2, 8'h02, "R9");
    // R5: clear drops edge bits, level line 1 survives
    rdReg(2'd3, 8'h02, "R5");
    rdReg(2'd2, 8'h02, "R5");
    idle(8'h00, "R5");
    // R6: rising edge coincides with clear read
    idle(8'h40, "R6");
    idle(8'h00, "R6");
    rdReg(2'd3, 8'h20, "R6");
    rdReg(2'd2, 8'h20, "R6");
    // R2: masking a pending edge line clears it
    wrReg(2'd0, 8'h20, 8'h20, "R2");
    rdReg(2'd2, 8'h20, "R2");
    idle(8'h00, "R2");
    idle(8'h20, "R2");
    rdReg(2'd2, 8'h20, "R2");
    wrReg(2'd0, 8'h00, 8'h00, "R2");
    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      case ($urandom % 6)
        0: wrReg(2'($urandom), 8'($urandom) & 8'h3C, r, "R7");
        1: rdReg(2'($urandom), r, "R5");
        default: idle(r, "R7");
      endcase
    end
    idle(8'h00, "R8");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule